// File: doc/BRIEF.md
# Prioritized Interrupt Dispatch Unit

This block decides, on request, whether the highest pending interrupt level can be accepted by the processor. If it can, the block produces every architectural register update that accepting it implies, all in one clock cycle. The surrounding core supplies the pending level and the raised and enabled interrupt lines. It also supplies a table that says which lines belong to each level, the processor status word, the current program counter and the vector base register. The block returns the next program counter and the new status word, write strobes into the saved-PC, saved-status and double-exception PC registers, and a write into the exception cause register.

Interrupts above level 1 branch straight to a vector of their own. They save the PC and status word into the register pair of that level and raise the status word's interrupt level to the accepted level. A level-1 interrupt is turned into a general exception instead. It goes to the user vector or the kernel vector, or to the double-exception vector when the core is already handling an exception. Vectors can be relocated: the built-in default base is swapped for the value of the vector base register.

All results are registered. They appear for exactly one cycle after the rising edge that sampled a dispatch request, marked by a take pulse.

Top module: `irq_dispatch`

## Requirements
- R1: A dispatch happens only when the request input is high and all three of these hold: the pending level is between 1 and NUM_LEVELS; the pending level is strictly greater than the current level; and the mask slice for that level ANDed with the set lines and the enabled lines is nonzero. The mask slice for level L is bits [(L-1)*NUM_LINES +: NUM_LINES] of the mask input.
- R2: The current level is the interrupt-level field, status bits [3:0]. When the exception-mode bit, status bit 4, is set, the current level is the larger of that field and EXCM_LEVEL.
- R3: For a level L above 1, bit L-1 of both the saved-PC and the saved-status write strobes is set. The saved data are the sampled PC and status word. The new status word has bits [3:0] replaced by L and bit 4 set.
- R4: For a level L above 1, the static target is DEF_VECBASE + LVL_OFS + (L-2)*LVL_STRIDE.
- R5: A level-1 dispatch writes cause code 4 with the cause strobe. Its new status word is the old one with bit 4 set and all other bits kept.
- R6: A level-1 dispatch while status bit 4 is set is a double exception (kind code 4) with static target DEF_VECBASE + DBL_OFS. The PC is saved through the double-exception strobe when HAS_DEPC is 1, and through saved-PC strobe bit 0 otherwise.
- R7: A level-1 dispatch while status bit 4 is clear saves the PC through saved-PC strobe bit 0. The user-mode bit, status bit 5, then chooses the target. When it is set, the kind is user (code 3) and the target is DEF_VECBASE + USR_OFS. When it is clear, the kind is kernel (code 2) and the target is DEF_VECBASE + KER_OFS. A high-level dispatch has kind code 1.
- R8: With RELOC_EN = 1 the new PC is the static target minus DEF_VECBASE plus the vector base input. With RELOC_EN = 0 the new PC is the static target.
- R9: All outputs are registered and appear in the cycle after the sampling edge. In any cycle without a take pulse, and throughout reset, every output is zero, including kind code 0.
- R10: With the request input low, no dispatch occurs, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eval_en_i | input | 1 | Dispatch request for this cycle |
| pend_level_i | input | LVLW | Pending interrupt level |
| int_set_i | input | NUM_LINES | Raised interrupt lines |
| int_enable_i | input | NUM_LINES | Enabled interrupt lines |
| lvl_mask_i | input | NUM_LEVELS*NUM_LINES | Per-level line membership table |
| ps_i | input | XLEN | Current processor status word |
| pc_i | input | XLEN | Current program counter |
| vecbase_i | input | XLEN | Vector base register |
| take_o | output | 1 | One-cycle dispatch pulse |
| kind_o | output | 3 | Dispatch kind: 0 none, 1 high, 2 kernel, 3 user, 4 double |
| pc_new_o | output | XLEN | Next program counter |
| ps_new_o | output | XLEN | Updated status word |
| epc_we_o | output | NUM_LEVELS | Saved-PC write strobes, bit L-1 for level L |
| eps_we_o | output | NUM_LEVELS | Saved-status write strobes, bit L-1 for level L |
| depc_we_o | output | 1 | Double-exception PC write strobe |
| save_pc_o | output | XLEN | Data for the saved-PC writes |
| save_ps_o | output | XLEN | Data for the saved-status write |
| cause_we_o | output | 1 | Exception cause write strobe |
| cause_o | output | 6 | Exception cause value |

## Verification
Every result of a request is due in the cycle after the rising edge that samples it, so each output is a single register stage behind its inputs. The bench computes the expected outputs at that rising edge from the inputs it sees there. It compares them with the outputs at the following falling edge, while the inputs for the next request are applied just after that falling edge. Two instances with different configurations run on the same stimulus, so that the double-exception path, the missing double-exception register and the unrelocated vectors are all compared every cycle.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;
   localparam int PS_INTLVL_W = 4;
   localparam int PS_EXCM_BIT = 4;
   localparam int PS_UM_BIT   = 5;
   localparam int CAUSE_W     = 6;
   localparam logic [CAUSE_W-1:0] CAUSE_LEVEL1_IRQ = 6'd4;

   typedef enum logic [2:0] {
      DISP_NONE   = 3'd0,
      DISP_HIGH   = 3'd1,
      DISP_KERNEL = 3'd2,
      DISP_USER   = 3'd3,
      DISP_DOUBLE = 3'd4
   } disp_kind_e;
endpackage

// File: rtl/irq_take_gate.sv
module irq_take_gate
   import irq_dispatch_pkg::*;
#(
   parameter int NUM_LEVELS = 6,
   parameter int NUM_LINES  = 32,
   parameter int LVLW       = 3,
   parameter int EXCM_LEVEL = 3
) (
   input  logic                            eval_en_i,
   input  logic [LVLW-1:0]                 pend_level_i,
   input  logic [NUM_LINES-1:0]            int_set_i,
   input  logic [NUM_LINES-1:0]            int_enable_i,
   input  logic [NUM_LEVELS*NUM_LINES-1:0] lvl_mask_i,
   input  logic [PS_INTLVL_W-1:0]          ps_intlvl_i,
   input  logic                            ps_excm_i,
   output logic                            take_o
);
   localparam int CMPW = (LVLW > PS_INTLVL_W) ? LVLW : PS_INTLVL_W;
   localparam logic [CMPW-1:0] EXCM_LV = CMPW'(EXCM_LEVEL);

   logic [NUM_LEVELS-1:0] lvl_hit;
   logic [CMPW-1:0]       cur_lvl;
   logic [CMPW-1:0]       pend_ext;
   logic                  sel_hit;

   for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_lvl_hit
      assign lvl_hit[l] = |(lvl_mask_i[l*NUM_LINES +: NUM_LINES] & int_set_i & int_enable_i);
   end

   assign pend_ext = CMPW'(pend_level_i);

   always_comb begin
      cur_lvl = CMPW'(ps_intlvl_i);
      if (ps_excm_i && (EXCM_LV > cur_lvl)) begin
         cur_lvl = EXCM_LV;
      end
   end

   always_comb begin
      sel_hit = 1'b0;
      for (int l = 0; l < NUM_LEVELS; l++) begin
         if (pend_ext == CMPW'(l + 1)) begin
            sel_hit = lvl_hit[l];
         end
      end
   end

   assign take_o = eval_en_i & sel_hit & (pend_ext > cur_lvl);
endmodule

// File: rtl/irq_vector_sel.sv
module irq_vector_sel
   import irq_dispatch_pkg::*;
#(
   parameter int               XLEN        = 32,
   parameter int               NUM_LEVELS  = 6,
   parameter int               LVLW        = 3,
   parameter bit               RELOC_EN    = 1'b1,
   parameter logic [XLEN-1:0]  DEF_VECBASE = 'h4000_0000,
   parameter int unsigned      KER_OFS     = 'h300,
   parameter int unsigned      USR_OFS     = 'h340,
   parameter int unsigned      DBL_OFS     = 'h3C0,
   parameter int unsigned      LVL_OFS     = 'h180,
   parameter int unsigned      LVL_STRIDE  = 'h40
) (
   input  disp_kind_e       kind_i,
   input  logic [LVLW-1:0]  level_i,
   input  logic [XLEN-1:0]  vecbase_i,
   output logic [XLEN-1:0]  target_o
);
   logic [XLEN-1:0] lvl_vec [NUM_LEVELS+1];
   logic [XLEN-1:0] stat_vec;

   for (genvar l = 0; l <= NUM_LEVELS; l++) begin : g_lvl_vec
      if (l >= 2) begin : g_high
         assign lvl_vec[l] = DEF_VECBASE + XLEN'(LVL_OFS) + XLEN'((l - 2) * LVL_STRIDE);
      end else begin : g_low
         assign lvl_vec[l] = DEF_VECBASE + XLEN'(LVL_OFS);
      end
   end

   always_comb begin
      stat_vec = '0;
      unique case (kind_i)
         DISP_HIGH: begin
            for (int l = 2; l <= NUM_LEVELS; l++) begin
               if (level_i == LVLW'(l)) stat_vec = lvl_vec[l];
            end
         end
         DISP_KERNEL: stat_vec = DEF_VECBASE + XLEN'(KER_OFS);
         DISP_USER:   stat_vec = DEF_VECBASE + XLEN'(USR_OFS);
         DISP_DOUBLE: stat_vec = DEF_VECBASE + XLEN'(DBL_OFS);
         default:     stat_vec = '0;
      endcase
   end

   if (RELOC_EN) begin : g_reloc
      assign target_o = stat_vec - DEF_VECBASE + vecbase_i;
   end else begin : g_fixed
      logic unused_vb;
      assign unused_vb = ^vecbase_i;
      assign target_o  = stat_vec;
   end
endmodule

// File: rtl/irq_commit.sv
module irq_commit
   import irq_dispatch_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter int NUM_LEVELS = 6,
   parameter int LVLW       = 3,
   parameter bit HAS_DEPC   = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  take_i,
   input  disp_kind_e            kind_i,
   input  logic [LVLW-1:0]       level_i,
   input  logic [XLEN-1:0]       pc_i,
   input  logic [XLEN-1:0]       ps_i,
   input  logic [XLEN-1:0]       target_i,
   output logic                  take_o,
   output logic [2:0]            kind_o,
   output logic [XLEN-1:0]       pc_new_o,
   output logic [XLEN-1:0]       ps_new_o,
   output logic [NUM_LEVELS-1:0] epc_we_o,
   output logic [NUM_LEVELS-1:0] eps_we_o,
   output logic                  depc_we_o,
   output logic [XLEN-1:0]       save_pc_o,
   output logic [XLEN-1:0]       save_ps_o,
   output logic                  cause_we_o,
   output logic [CAUSE_W-1:0]    cause_o
);
   localparam logic [XLEN-1:0] EXCM_MASK = XLEN'(1) << PS_EXCM_BIT;
   localparam logic [XLEN-1:0] ILVL_MASK = XLEN'((1 << PS_INTLVL_W) - 1);

   logic [NUM_LEVELS-1:0] lvl_onehot;
   logic [NUM_LEVELS-1:0] epc_we_d, eps_we_d;
   logic                  depc_we_d, cause_we_d;
   logic [XLEN-1:0]       ps_new_d;

   for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_onehot
      assign lvl_onehot[l] = (level_i == LVLW'(l + 1));
   end

   always_comb begin
      epc_we_d   = '0;
      eps_we_d   = '0;
      depc_we_d  = 1'b0;
      cause_we_d = 1'b0;
      ps_new_d   = ps_i | EXCM_MASK;
      unique case (kind_i)
         DISP_HIGH: begin
            epc_we_d = lvl_onehot;
            eps_we_d = lvl_onehot;
            ps_new_d = (ps_i & ~ILVL_MASK) | XLEN'(level_i) | EXCM_MASK;
         end
         DISP_KERNEL, DISP_USER: begin
            epc_we_d[0] = 1'b1;
            cause_we_d  = 1'b1;
         end
         DISP_DOUBLE: begin
            cause_we_d = 1'b1;
            if (HAS_DEPC) depc_we_d   = 1'b1;
            else          epc_we_d[0] = 1'b1;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !take_i) begin
         take_o     <= 1'b0;
         kind_o     <= DISP_NONE;
         pc_new_o   <= '0;
         ps_new_o   <= '0;
         epc_we_o   <= '0;
         eps_we_o   <= '0;
         depc_we_o  <= 1'b0;
         save_pc_o  <= '0;
         save_ps_o  <= '0;
         cause_we_o <= 1'b0;
         cause_o    <= '0;
      end else begin
         take_o     <= 1'b1;
         kind_o     <= kind_i;
         pc_new_o   <= target_i;
         ps_new_o   <= ps_new_d;
         epc_we_o   <= epc_we_d;
         eps_we_o   <= eps_we_d;
         depc_we_o  <= depc_we_d;
         save_pc_o  <= pc_i;
         save_ps_o  <= ps_i;
         cause_we_o <= cause_we_d;
         cause_o    <= cause_we_d ? CAUSE_LEVEL1_IRQ : '0;
      end
   end

   AST_STROBE_NEEDS_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      ((|epc_we_o) || (|eps_we_o) || depc_we_o || cause_we_o) |-> take_o); // R9
   AST_ONE_PC_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({epc_we_o, depc_we_o})); // R6
   AST_EXCM_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> ps_new_o[PS_EXCM_BIT]); // R5
   AST_CAUSE_ONLY_LEVEL1: assert property (@(posedge clk) disable iff (!rst_n)
      cause_we_o |-> (kind_o != 3'(DISP_HIGH)) && (eps_we_o == '0)); // R5
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
   import irq_dispatch_pkg::*;
#(
   parameter int               XLEN        = 32,
   parameter int               NUM_LEVELS  = 6,
   parameter int               NUM_LINES   = 32,
   parameter int               EXCM_LEVEL  = 3,
   parameter bit               HAS_DEPC    = 1'b1,
   parameter bit               RELOC_EN    = 1'b1,
   parameter logic [XLEN-1:0]  DEF_VECBASE = 'h4000_0000,
   parameter int unsigned      KER_OFS     = 'h300,
   parameter int unsigned      USR_OFS     = 'h340,
   parameter int unsigned      DBL_OFS     = 'h3C0,
   parameter int unsigned      LVL_OFS     = 'h180,
   parameter int unsigned      LVL_STRIDE  = 'h40,
   localparam int              LVLW        = $clog2(NUM_LEVELS + 2)
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            eval_en_i,
   input  logic [LVLW-1:0]                 pend_level_i,
   input  logic [NUM_LINES-1:0]            int_set_i,
   input  logic [NUM_LINES-1:0]            int_enable_i,
   input  logic [NUM_LEVELS*NUM_LINES-1:0] lvl_mask_i,
   input  logic [XLEN-1:0]                 ps_i,
   input  logic [XLEN-1:0]                 pc_i,
   input  logic [XLEN-1:0]                 vecbase_i,
   output logic                            take_o,
   output logic [2:0]                      kind_o,
   output logic [XLEN-1:0]                 pc_new_o,
   output logic [XLEN-1:0]                 ps_new_o,
   output logic [NUM_LEVELS-1:0]           epc_we_o,
   output logic [NUM_LEVELS-1:0]           eps_we_o,
   output logic                            depc_we_o,
   output logic [XLEN-1:0]                 save_pc_o,
   output logic [XLEN-1:0]                 save_ps_o,
   output logic                            cause_we_o,
   output logic [CAUSE_W-1:0]              cause_o
);
   if (XLEN < 8) begin : g_bad_xlen
      $error("irq_dispatch: XLEN must hold the status fields");
   end
   if (NUM_LEVELS < 2 || NUM_LEVELS > 13) begin : g_bad_levels
      $error("irq_dispatch: NUM_LEVELS out of range 2..13");
   end
   if (NUM_LINES < 1) begin : g_bad_lines
      $error("irq_dispatch: NUM_LINES must be positive");
   end
   if (EXCM_LEVEL < 0 || EXCM_LEVEL > NUM_LEVELS) begin : g_bad_excm
      $error("irq_dispatch: EXCM_LEVEL out of range");
   end

   logic            take_d;
   disp_kind_e      kind_d;
   logic [XLEN-1:0] target_d;

   irq_take_gate #(
      .NUM_LEVELS (NUM_LEVELS),
      .NUM_LINES  (NUM_LINES),
      .LVLW       (LVLW),
      .EXCM_LEVEL (EXCM_LEVEL)
   ) u_gate (
      .eval_en_i    (eval_en_i),
      .pend_level_i (pend_level_i),
      .int_set_i    (int_set_i),
      .int_enable_i (int_enable_i),
      .lvl_mask_i   (lvl_mask_i),
      .ps_intlvl_i  (ps_i[PS_INTLVL_W-1:0]),
      .ps_excm_i    (ps_i[PS_EXCM_BIT]),
      .take_o       (take_d)
   );

   always_comb begin
      kind_d = DISP_NONE;
      if (take_d) begin
         if (pend_level_i != LVLW'(1))  kind_d = DISP_HIGH;
         else if (ps_i[PS_EXCM_BIT])    kind_d = DISP_DOUBLE;
         else if (ps_i[PS_UM_BIT])      kind_d = DISP_USER;
         else                           kind_d = DISP_KERNEL;
      end
   end

   irq_vector_sel #(
      .XLEN        (XLEN),
      .NUM_LEVELS  (NUM_LEVELS),
      .LVLW        (LVLW),
      .RELOC_EN    (RELOC_EN),
      .DEF_VECBASE (DEF_VECBASE),
      .KER_OFS     (KER_OFS),
      .USR_OFS     (USR_OFS),
      .DBL_OFS     (DBL_OFS),
      .LVL_OFS     (LVL_OFS),
      .LVL_STRIDE  (LVL_STRIDE)
   ) u_vec (
      .kind_i    (kind_d),
      .level_i   (pend_level_i),
      .vecbase_i (vecbase_i),
      .target_o  (target_d)
   );

   irq_commit #(
      .XLEN       (XLEN),
      .NUM_LEVELS (NUM_LEVELS),
      .LVLW       (LVLW),
      .HAS_DEPC   (HAS_DEPC)
   ) u_commit (
      .clk        (clk),
      .rst_n      (rst_n),
      .take_i     (take_d),
      .kind_i     (kind_d),
      .level_i    (pend_level_i),
      .pc_i       (pc_i),
      .ps_i       (ps_i),
      .target_i   (target_d),
      .take_o     (take_o),
      .kind_o     (kind_o),
      .pc_new_o   (pc_new_o),
      .ps_new_o   (ps_new_o),
      .epc_we_o   (epc_we_o),
      .eps_we_o   (eps_we_o),
      .depc_we_o  (depc_we_o),
      .save_pc_o  (save_pc_o),
      .save_ps_o  (save_ps_o),
      .cause_we_o (cause_we_o),
      .cause_o    (cause_o)
   );

   AST_IDLE_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(eval_en_i) |-> !take_o); // R10
   AST_HIGH_RAISES_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (take_o && kind_o == 3'(DISP_HIGH)) |->
         (ps_new_o[PS_INTLVL_W-1:0] > $past(ps_i[PS_INTLVL_W-1:0]))); // R2
   AST_TAKE_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> ($past(pend_level_i) != '0) &&
                 ($past(pend_level_i) <= LVLW'(NUM_LEVELS))); // R1
endmodule

// File: tb/irq_dispatch_tb.sv
`timescale 1ns/1ps
module irq_dispatch_tb;
   localparam int NL = 6;
   localparam int NW = 32;
   localparam logic [31:0] DEFV = 32'h4000_0000;

   typedef struct packed {
      logic        take;
      logic [2:0]  kind;
      logic [31:0] pc_new;
      logic [31:0] ps_new;
      logic [5:0]  epc_we;
      logic [5:0]  eps_we;
      logic        depc_we;
      logic [31:0] save_pc;
      logic [31:0] save_ps;
      logic        cause_we;
      logic [5:0]  cause;
   } obs_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic eval_en = 1'b0;
   logic [2:0] pend = '0;
   logic [NW-1:0] iset = '0, ien = '0;
   logic [NL*NW-1:0] mask = '0;
   logic [31:0] ps = '0, pc = '0, vb = '0;
   int n_tests = 0, n_fail = 0;
   string cur_tag = "R9";
   obs_t act_a, act_b, exp_a, exp_b;

   always #10 clk = ~clk;

   irq_dispatch u_dut (
      .clk(clk), .rst_n(rst_n), .eval_en_i(eval_en), .pend_level_i(pend),
      .int_set_i(iset), .int_enable_i(ien), .lvl_mask_i(mask), .ps_i(ps),
      .pc_i(pc), .vecbase_i(vb), .take_o(act_a.take), .kind_o(act_a.kind),
      .pc_new_o(act_a.pc_new), .ps_new_o(act_a.ps_new), .epc_we_o(act_a.epc_we),
      .eps_we_o(act_a.eps_we), .depc_we_o(act_a.depc_we), .save_pc_o(act_a.save_pc),
      .save_ps_o(act_a.save_ps), .cause_we_o(act_a.cause_we), .cause_o(act_a.cause));

   irq_dispatch #(.EXCM_LEVEL(0), .HAS_DEPC(1'b0), .RELOC_EN(1'b0)) u_dut_alt (
      .clk(clk), .rst_n(rst_n), .eval_en_i(eval_en), .pend_level_i(pend),
      .int_set_i(iset), .int_enable_i(ien), .lvl_mask_i(mask), .ps_i(ps),
      .pc_i(pc), .vecbase_i(vb), .take_o(act_b.take), .kind_o(act_b.kind),
      .pc_new_o(act_b.pc_new), .ps_new_o(act_b.ps_new), .epc_we_o(act_b.epc_we),
      .eps_we_o(act_b.eps_we), .depc_we_o(act_b.depc_we), .save_pc_o(act_b.save_pc),
      .save_ps_o(act_b.save_ps), .cause_we_o(act_b.cause_we), .cause_o(act_b.cause));

   function automatic obs_t model(int excm_lvl, bit has_depc, bit reloc);
      obs_t e;
      int cur, pl;
      bit hit;
      logic [31:0] stat;
      e = '0;
      pl = int'(pend);
      cur = int'(ps[3:0]);
      if (ps[4] && excm_lvl > cur) cur = excm_lvl;
      hit = 1'b0;
      if (pl >= 1 && pl <= NL) hit = |(mask[(pl-1)*NW +: NW] & iset & ien);
      if (!(eval_en && hit && pl > cur)) return e;
      e.take = 1'b1;
      e.save_pc = pc;
      e.save_ps = ps;
      if (pl > 1) begin
         e.kind = 3'd1;
         e.epc_we[pl-1] = 1'b1;
         e.eps_we[pl-1] = 1'b1;
         e.ps_new = {ps[31:4], 4'(pl)} | 32'h10;
         stat = DEFV + 32'h180 + 32'(pl - 2) * 32'h40;
      end else begin
         e.cause_we = 1'b1;
         e.cause = 6'd4;
         e.ps_new = ps | 32'h10;
         if (ps[4]) begin
            e.kind = 3'd4;
            if (has_depc) e.depc_we = 1'b1;
            else          e.epc_we[0] = 1'b1;
            stat = DEFV + 32'h3C0;
         end else begin
            e.epc_we[0] = 1'b1;
            e.kind = ps[5] ? 3'd3 : 3'd2;
            stat = DEFV + (ps[5] ? 32'h340 : 32'h300);
         end
      end
      e.pc_new = reloc ? stat - DEFV + vb : stat;
      return e;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         exp_a = '0;
         exp_b = '0;
      end else begin
         exp_a = model(3, 1'b1, 1'b1);
         exp_b = model(0, 1'b0, 1'b0);
      end
   end

   task automatic chk(string who, string tag, logic [31:0] a, logic [31:0] e);
      n_tests++;
      if (a !== e) begin
         n_fail++;
         $display("FAIL %s %s (phase %s): actual %h expected %h", tag, who, cur_tag, a, e);
      end
   endtask

   task automatic cmp_all(string who, obs_t a, obs_t e);
      chk({who, ".take"}, "R1", 32'(a.take), 32'(e.take));
      chk({who, ".kind"}, "R7", 32'(a.kind), 32'(e.kind));
      chk({who, ".pc_new"}, "R4", a.pc_new, e.pc_new);
      chk({who, ".ps_new"}, "R3", a.ps_new, e.ps_new);
      chk({who, ".epc_we"}, "R3", 32'(a.epc_we), 32'(e.epc_we));
      chk({who, ".eps_we"}, "R3", 32'(a.eps_we), 32'(e.eps_we));
      chk({who, ".depc_we"}, "R6", 32'(a.depc_we), 32'(e.depc_we));
      chk({who, ".save_pc"}, "R3", a.save_pc, e.save_pc);
      chk({who, ".save_ps"}, "R3", a.save_ps, e.save_ps);
      chk({who, ".cause_we"}, "R5", 32'(a.cause_we), 32'(e.cause_we));
      chk({who, ".cause"}, "R5", 32'(a.cause), 32'(e.cause));
   endtask

   logic started = 1'b0;
   always @(negedge clk) begin
      if (started) begin
         cmp_all("u_dut", act_a, exp_a);
         cmp_all("u_dut_alt", act_b, exp_b);
      end
   end

   task automatic step(bit ev, int pl, logic [31:0] s, logic [31:0] en,
                       logic [31:0] p, logic [31:0] c, logic [31:0] v);
      @(negedge clk);
      #1;
      eval_en = ev; pend = 3'(pl); iset = s; ien = en; ps = p; pc = c; vb = v;
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      mask = {NL*NW{1'b1}};
      cur_tag = "R9";
      started = 1'b1;
      repeat (3) @(negedge clk);
      #1 rst_n = 1'b1;

      // R1: enable gate, equal level, out-of-range level, empty mask slice
      cur_tag = "R1";
      step(1, 3, 32'h1, 32'h0, 32'h0, 32'h100, 32'h0);
      step(1, 2, 32'h1, 32'h1, 32'h2, 32'h104, 32'h0);
      step(1, 7, 32'h1, 32'h1, 32'h0, 32'h108, 32'h0);
      step(1, 0, 32'h1, 32'h1, 32'h0, 32'h10C, 32'h0);
      step(0, 0, 0, 0, 0, 0, 0);
      mask[2*NW +: NW] = 32'h0000_0F00;
      step(1, 3, 32'h0000_00FF, 32'hFFFF_FFFF, 32'h0, 32'h110, 32'h0);
      step(1, 3, 32'h0000_0100, 32'hFFFF_FFFF, 32'h0, 32'h114, 32'h0);
      step(0, 0, 0, 0, 0, 0, 0);
      mask = {NL*NW{1'b1}};

      // R2: exception mode raises current level in u_dut only
      cur_tag = "R2";
      step(1, 3, 32'h8, 32'h8, 32'h10, 32'h200, 32'h0);
      step(1, 4, 32'h8, 32'h8, 32'h10, 32'h204, 32'h0);
      step(1, 2, 32'h8, 32'h8, 32'h11, 32'h208, 32'h0);

      // R3 R4: every high level from level 0
      cur_tag = "R3 R4";
      for (int l = 2; l <= NL; l++) step(1, l, 32'hFFFF, 32'hFFFF, 32'hABCD_0020, 32'h300 + 32'(l), DEFV);

      // R5 R7: kernel and user conversions
      cur_tag = "R5 R7";
      step(1, 1, 32'h1, 32'h1, 32'h0000_0000, 32'h400, DEFV);
      step(1, 1, 32'h1, 32'h1, 32'h0000_0020, 32'h404, DEFV);

      // R6: double exception, only reachable in u_dut_alt
      cur_tag = "R6";
      step(1, 1, 32'h1, 32'h1, 32'h0000_0010, 32'h500, DEFV);
      step(1, 1, 32'h1, 32'h1, 32'h0000_0030, 32'h504, DEFV);

      // R8: relocated vector base
      cur_tag = "R8";
      step(1, 5, 32'h10, 32'h10, 32'h0, 32'h600, 32'h8000_0000);
      step(1, 1, 32'h10, 32'h10, 32'h0, 32'h604, 32'h1234_5000);

      // R10: request low blocks everything
      cur_tag = "R10";
      step(0, 6, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h700, 32'h0);
      step(0, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h704, 32'h0);

      // R9: back-to-back pulses then idle
      cur_tag = "R9";
      step(1, 6, 32'h1, 32'h1, 32'h0, 32'h800, 32'h0);
      step(1, 6, 32'h1, 32'h1, 32'h0, 32'h804, 32'h0);
      step(0, 0, 0, 0, 0, 0, 0);

      cur_tag = "random R1 R2 R3";
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] p;
         for (int l = 0; l < NL; l++) mask[l*NW +: NW] = $urandom() & $urandom();
         p = $urandom();
         p[3:0] = 4'($urandom_range(0, 5));
         step(($urandom_range(0, 7) != 0), $urandom_range(0, 7), $urandom(), $urandom(),
              p, $urandom(), $urandom());
      end
      step(0, 0, 0, 0, 0, 0, 0);
      @(negedge clk);
      @(negedge clk);
      #1;
      finish_run();
   end
endmodule